// File: doc/BRIEF.md
# External Memory Chip-Enable Controller

This block turns each external memory access of an 8051-style core into chip-enable, peripheral-chip-enable and read/write/program-strobe pins. The address is split into eight equal regions. Each region drives one active-low chip enable. A data access to one of the upper four regions can instead drive one of four active-low peripheral enables. A per-region combined bit lets one chip enable serve both program fetches and data accesses. This suits external flash that is read as code and rewritten by data writes.

The lower four regions have a programmable write-protect window that starts at offset zero. A data write that lands inside an enabled window is dropped. The block then raises a one-cycle blocked pulse and sets a sticky flag, and the flag can raise an interrupt. The protection settings and the flag live in one register held inside the block.

Requests are taken every cycle and decoded by a three-state machine. ST_IDLE means no strobe. ST_STROBE drives the strobes that were decoded for the previous request. ST_BLOCK marks a dropped write. The machine has three transitions, and each one can be taken from any state. The transition to ST_STROBE is taken on an accepted access. The transition to ST_BLOCK is taken on a protected write. The transition to ST_IDLE is taken when there is no request. Every output therefore follows its request by one cycle, and back-to-back requests give one strobe cycle each.

Top module: `xmem_ce_ctrl`

## Requirements
- R1: After reset, every ce_n, pce_n, rd_n, wr_n and psen_n is 1, wr_blocked and irq are 0, and wp_reg is 0.
- R2: A request with req_kind 00 (program fetch) drives ce_n[r] and psen_n low in the following cycle, whatever the combined bits. Here r = req_addr[21:19] and the region offset is req_addr[18:0].
- R3: A data read (kind 01) or data write (kind 10) to a region r whose combined bit is clear asserts no chip enable. It drives rd_n low for a read and wr_n low for a write. If r is 4..7 it also drives pce_n[r-4] low.
- R4: comb_lo_nib[k] is the combined bit of region k and comb_hi_nib[k] that of region k+4. A data access to a combined region drives ce_n[r] low, and no peripheral enable asserts.
- R5: In a combined region a data read drives psen_n low and leaves rd_n high. A data write drives wr_n low.
- R6: wp_reg holds the enable bit of region k (k=0..3) in bit k, a range code c in bits 6:4, and the sticky flag in bit 7. The protected window covers offsets 0 to (c+1)*2048-1 of each enabled region.
- R7: A data write inside an enabled window drives no chip enable, no peripheral enable and no wr_n. wr_blocked is 1 for that one cycle, and wp_reg[7] is 1 from then on.
- R8: Reads and fetches inside a window are served normally. So are writes at or above the window limit, and writes to a region whose enable bit is clear.
- R9: A wp_we write loads bits 6:0 from wp_wdata. A 0 in wp_wdata[7] clears the flag and a 1 leaves it as it is. A violation in the same cycle as a clear leaves the flag set.
- R10: irq is 1 exactly when wp_reg[7] is 1 and wp_irq_en is 1.
- R11: With req_valid low, or with req_kind 11, no enable or strobe asserts in the following cycle.
- R12: Requests on consecutive cycles each produce exactly one cycle of their own strobes, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 none |
| req_addr | input | 22 | Access address |
| comb_hi_nib | input | 4 | Combined bits for regions 7..4 |
| comb_lo_nib | input | 4 | Combined bits for regions 3..0 |
| wp_we | input | 1 | Write strobe for the protection register |
| wp_wdata | input | 8 | Protection register write data |
| wp_irq_en | input | 1 | Write-protect interrupt enable |
| ce_n | output | 8 | Active-low chip enables |
| pce_n | output | 4 | Active-low peripheral chip enables |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low write strobe |
| psen_n | output | 1 | Active-low program strobe |
| wr_blocked | output | 1 | One-cycle pulse for a dropped write |
| wp_reg | output | 8 | Protection register and sticky flag |
| irq | output | 1 | Write-protect interrupt request |

## Verification
The bench builds the block with its default parameters: a 22-bit address, 512 KB regions, a 2 KB window step and a 3-bit range code. Every window, up to 16 KB, then lies well inside a region. This brings both edges of each of the eight range codes within reach: the last protected byte and the first open byte. Those edges are driven for every range code across the protectable regions. Reads and fetches inside windows, combined and plain regions, the sticky flag with a clear in the same cycle as a violation, and back-to-back requests are compared cycle by cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_DRD   = 2'b01,
        KIND_DWR   = 2'b10,
        KIND_NONE  = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_STROBE = 2'b01,
        ST_BLOCK  = 2'b10
    } xm_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ps;
    } strobe_t;

endpackage

// File: rtl/xmem_region_decode.sv
module xmem_region_decode
    import xmem_pkg::*;
#(
    parameter int REG_W = 3,
    localparam int CE_N = 1 << REG_W,
    localparam int HALF = CE_N / 2
) (
    input  logic             active,
    input  acc_kind_t        kind,
    input  logic [REG_W-1:0] region,
    input  logic [CE_N-1:0]  comb,
    output logic [CE_N-1:0]  ce_vec,
    output logic [HALF-1:0]  pce_vec,
    output strobe_t          stb
);

    logic is_data;
    logic is_fetch;
    logic reg_comb;

    assign is_data  = (kind == KIND_DRD) || (kind == KIND_DWR);
    assign is_fetch = (kind == KIND_FETCH);
    assign reg_comb = comb[region];

    for (genvar g = 0; g < CE_N; g++) begin : g_ce
        logic hit;
        assign hit = active && (region == REG_W'(g));
        assign ce_vec[g] = hit && (is_fetch || (is_data && comb[g]));
        if (g >= HALF) begin : g_pce
            assign pce_vec[g-HALF] = hit && is_data && !comb[g];
        end
    end

    always_comb begin
        stb = '0;
        if (active) begin
            unique case (kind)
                KIND_FETCH: stb.ps = 1'b1;
                KIND_DRD: begin
                    if (reg_comb) stb.ps = 1'b1;
                    else          stb.rd = 1'b1;
                end
                KIND_DWR:  stb.wr = 1'b1;
                KIND_NONE: stb = '0;
            endcase
        end
    end

endmodule

// File: rtl/xmem_wp_check.sv
module xmem_wp_check #(
    parameter int REG_W   = 3,
    parameter int OFF_W   = 19,
    parameter int STEP_W  = 11,
    parameter int RANGE_W = 3,
    localparam int HALF   = (1 << REG_W) / 2,
    localparam int CFG_W  = HALF + RANGE_W
) (
    input  logic             is_write,
    input  logic [REG_W-1:0] region,
    input  logic [OFF_W-1:0] offset,
    input  logic [CFG_W-1:0] cfg,
    output logic             viol
);

    logic [HALF-1:0]    en;
    logic [RANGE_W-1:0] code;
    logic [OFF_W-1:0]   limit;
    logic               low_region;

    assign en         = cfg[HALF-1:0];
    assign code       = cfg[CFG_W-1:HALF];
    assign limit      = OFF_W'({1'b0, code} + (RANGE_W+1)'(1)) << STEP_W;
    assign low_region = !region[REG_W-1];

    assign viol = is_write && low_region && en[region[REG_W-2:0]] && (offset < limit);

endmodule

// File: rtl/xmem_wp_reg.sv
module xmem_wp_reg #(
    parameter int WPR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WPR_W-1:0] wdata,
    input  logic             viol,
    output logic [WPR_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we) q[WPR_W-2:0] <= wdata[WPR_W-2:0];
            q[WPR_W-1] <= viol || (q[WPR_W-1] && !(we && !wdata[WPR_W-1]));
        end
    end

endmodule

// File: rtl/xmem_ce_ctrl.sv
module xmem_ce_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int REGION_SHIFT = 19,
    parameter int STEP_W       = 11,
    parameter int RANGE_W      = 3,
    localparam int REG_W = ADDR_W - REGION_SHIFT,
    localparam int CE_N  = 1 << REG_W,
    localparam int HALF  = CE_N / 2,
    localparam int WPR_W = HALF + RANGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF-1:0]   comb_hi_nib,
    input  logic [HALF-1:0]   comb_lo_nib,
    input  logic              wp_we,
    input  logic [WPR_W-1:0]  wp_wdata,
    input  logic              wp_irq_en,
    output logic [CE_N-1:0]   ce_n,
    output logic [HALF-1:0]   pce_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n,
    output logic              wr_blocked,
    output logic [WPR_W-1:0]  wp_reg,
    output logic              irq
);

    acc_kind_t         kind;
    logic [REG_W-1:0]  region;
    logic [REGION_SHIFT-1:0] offset;
    logic              active;
    logic              viol;
    logic [CE_N-1:0]   ce_vec;
    logic [HALF-1:0]   pce_vec;
    strobe_t           stb;

    xm_state_t         state, state_nx;
    logic [CE_N-1:0]   ce_q;
    logic [HALF-1:0]   pce_q;
    strobe_t           stb_q;

    assign kind   = acc_kind_t'(req_kind);
    assign region = req_addr[ADDR_W-1:REGION_SHIFT];
    assign offset = req_addr[REGION_SHIFT-1:0];
    assign active = req_valid && (kind != KIND_NONE);

    xmem_region_decode #(.REG_W(REG_W)) u_dec (
        .active  (active),
        .kind    (kind),
        .region  (region),
        .comb    ({comb_hi_nib, comb_lo_nib}),
        .ce_vec  (ce_vec),
        .pce_vec (pce_vec),
        .stb     (stb)
    );

    xmem_wp_check #(
        .REG_W   (REG_W),
        .OFF_W   (REGION_SHIFT),
        .STEP_W  (STEP_W),
        .RANGE_W (RANGE_W)
    ) u_chk (
        .is_write (active && (kind == KIND_DWR)),
        .region   (region),
        .offset   (offset),
        .cfg      (wp_reg[WPR_W-2:0]),
        .viol     (viol)
    );

    xmem_wp_reg #(.WPR_W(WPR_W)) u_wpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wp_we),
        .wdata (wp_wdata),
        .viol  (viol),
        .q     (wp_reg)
    );

    // next state: the same three transitions are open from every state
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_STROBE, ST_BLOCK: begin
                if (viol)        state_nx = ST_BLOCK;
                else if (active) state_nx = ST_STROBE;
                else             state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ce_q  <= '0;
            pce_q <= '0;
            stb_q <= '0;
        end else begin
            state <= state_nx;
            ce_q  <= ce_vec;
            pce_q <= pce_vec;
            stb_q <= stb;
        end
    end

    always_comb begin
        ce_n       = '1;
        pce_n      = '1;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        psen_n     = 1'b1;
        wr_blocked = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_STROBE: begin
                ce_n   = ~ce_q;
                pce_n  = ~pce_q;
                rd_n   = ~stb_q.rd;
                wr_n   = ~stb_q.wr;
                psen_n = ~stb_q.ps;
            end
            ST_BLOCK: wr_blocked = 1'b1;
            default: ;
        endcase
    end

    assign irq = wp_reg[WPR_W-1] && wp_irq_en;

endmodule

// File: rtl/xmem_ce_ctrl_chk.sv
module xmem_ce_ctrl_chk #(
    parameter int CE_N  = 8,
    parameter int HALF  = 4,
    parameter int WPR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             wp_we,
    input logic [WPR_W-1:0] wp_wdata,
    input logic             wp_irq_en,
    input logic [CE_N-1:0]  ce_n,
    input logic [HALF-1:0]  pce_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             psen_n,
    input logic             wr_blocked,
    input logic [WPR_W-1:0] wp_reg,
    input logic             irq
);

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ce_n, ~pce_n})); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rd_n, ~wr_n, ~psen_n})); // R5

    AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> (wr_n && (ce_n == '1) && (pce_n == '1))); // R7

    AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> wp_reg[WPR_W-1]); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wp_reg[WPR_W-1]) && !($past(wp_we) && !$past(wp_wdata[WPR_W-1])))
        |-> wp_reg[WPR_W-1]); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wp_reg[WPR_W-1] && wp_irq_en)); // R10

    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || (req_kind == 2'b11)) |=>
        ((ce_n == '1) && (pce_n == '1) && rd_n && wr_n && psen_n && !wr_blocked)); // R11

endmodule

bind xmem_ce_ctrl xmem_ce_ctrl_chk #(.CE_N(CE_N), .HALF(HALF), .WPR_W(WPR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .wp_we      (wp_we),
    .wp_wdata   (wp_wdata),
    .wp_irq_en  (wp_irq_en),
    .ce_n       (ce_n),
    .pce_n      (pce_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .psen_n     (psen_n),
    .wr_blocked (wr_blocked),
    .wp_reg     (wp_reg),
    .irq        (irq)
);

// File: tb/xmem_ce_ctrl_tb.sv
module xmem_ce_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b11;
    logic [21:0] req_addr = '0;
    logic [3:0]  comb_hi_nib = '0;
    logic [3:0]  comb_lo_nib = '0;
    logic        wp_we = 1'b0;
    logic [7:0]  wp_wdata = '0;
    logic        wp_irq_en = 1'b0;
    logic [7:0]  ce_n;
    logic [3:0]  pce_n;
    logic        rd_n, wr_n, psen_n, wr_blocked, irq;
    logic [7:0]  wp_reg;

    int checks = 0;
    int fails = 0;
    logic [7:0] m_wp = '0;
    logic [15:0] expq[$];
    string       tagq[$];

    always #5 clk = ~clk;

    xmem_ce_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .comb_hi_nib(comb_hi_nib), .comb_lo_nib(comb_lo_nib),
        .wp_we(wp_we), .wp_wdata(wp_wdata), .wp_irq_en(wp_irq_en),
        .ce_n(ce_n), .pce_n(pce_n), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
        .wr_blocked(wr_blocked), .wp_reg(wp_reg), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: pops one expected pin image per clock and compares it
    always begin
        @(posedge clk);
        #2;
        if (expq.size() > 0) begin
            string t;
            logic [15:0] e;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, {ce_n, pce_n, rd_n, wr_n, psen_n, wr_blocked}, e);
        end
    end

    // driver: one request per cycle, expected image pushed from the rules
    task automatic cyc(input string tag, input logic v, input logic [1:0] k,
                       input logic [21:0] a, input logic we = 1'b0,
                       input logic [7:0] wd = 8'h00);
        logic [2:0]  r;
        logic [18:0] off;
        logic [7:0]  combv;
        logic        cm, blk;
        logic [7:0]  ce;
        logic [3:0]  pce;
        logic        rd, wr, ps;
        int          lim;
        req_valid = v; req_kind = k; req_addr = a; wp_we = we; wp_wdata = wd;
        r = a[21:19]; off = a[18:0];
        combv = {comb_hi_nib, comb_lo_nib};
        cm = combv[r];
        lim = (int'(m_wp[6:4]) + 1) * 2048;
        blk = v && k == 2'b10 && r < 4 && m_wp[r[1:0]] && int'(off) < lim;
        ce = '1; pce = '1; rd = 1; wr = 1; ps = 1;
        if (v && k != 2'b11 && !blk) begin
            if (k == 2'b00) begin ce[r] = 0; ps = 0; end
            else begin
                if (cm) ce[r] = 0;
                else if (r >= 4) pce[r-4] = 0;
                if (k == 2'b10) wr = 0;
                else if (cm) ps = 0;
                else rd = 0;
            end
        end
        expq.push_back({ce, pce, rd, wr, ps, blk});
        tagq.push_back(tag);
        if (we) m_wp[6:0] = wd[6:0];
        m_wp[7] = blk || (m_wp[7] && !(we && !wd[7]));
        @(negedge clk);
        check({tag, " reg"}, {8'h00, wp_reg}, {8'h00, m_wp});
    endtask

    function automatic logic [21:0] ad(input int r, input int off);
        return {r[2:0], off[18:0]};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pins", {ce_n, pce_n, rd_n, wr_n, psen_n, wr_blocked}, 16'hFFFE);
        check("R1 reset reg", {7'h0, irq, wp_reg}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 fetches, R3 plain data, R12 back to back
        for (int r = 0; r < 8; r++) cyc("R2 fetch plain", 1, 2'b00, ad(r, 'h123));
        for (int r = 0; r < 8; r++) cyc("R3 read plain", 1, 2'b01, ad(r, 'h40));
        for (int r = 0; r < 8; r++) cyc("R3 write plain", 1, 2'b10, ad(r, 'h7FFFF));
        cyc("R11 idle", 0, 2'b01, ad(5, 0));
        cyc("R11 kind none", 1, 2'b11, ad(6, 0));
        cyc("R12 after none", 1, 2'b01, ad(6, 0));

        // R4 R5 combined regions
        comb_hi_nib = 4'b1010; comb_lo_nib = 4'b0101;
        for (int r = 0; r < 8; r++) cyc("R4 R5 read comb", 1, 2'b01, ad(r, 'h10));
        for (int r = 0; r < 8; r++) cyc("R4 write comb", 1, 2'b10, ad(r, 'h20));
        for (int r = 0; r < 8; r++) cyc("R2 fetch comb", 1, 2'b00, ad(r, 'h30));
        comb_hi_nib = 4'hF; comb_lo_nib = 4'hF;

        // R6 R7 R8 every range code at the window edge
        for (int c = 0; c < 8; c++) begin
            int lim;
            int r;
            lim = (c + 1) * 2048;
            r = c % 4;
            cyc("R6 set range", 0, 2'b11, 0, 1, {1'b0, c[2:0], 4'hF});
            cyc("R7 last protected", 1, 2'b10, ad(r, lim - 1));
            cyc("R6 first open", 1, 2'b10, ad(r, lim));
            cyc("R8 read in window", 1, 2'b01, ad(r, lim - 1));
            cyc("R8 fetch in window", 1, 2'b00, ad(r, 0));
            cyc("R7 offset zero", 1, 2'b10, ad((r + 1) % 4, 0));
        end
        // R8 enable bit clear and upper regions
        cyc("R8 clear en2", 0, 2'b11, 0, 1, 8'h7B);
        cyc("R8 write en clear", 1, 2'b10, ad(2, 5));
        cyc("R8 upper region", 1, 2'b10, ad(4, 5));
        comb_lo_nib = 4'h0;
        cyc("R7 plain protected", 1, 2'b10, ad(1, 5));
        cyc("R8 plain read", 1, 2'b01, ad(1, 5));

        // R10 interrupt gating
        wp_irq_en = 1'b0; #1;
        check("R10 irq masked", {15'h0, irq}, 16'h0000);
        wp_irq_en = 1'b1; #1;
        check("R10 irq raised", {15'h0, irq}, 16'h0001);
        // R9 flag write rules
        cyc("R9 write one keeps", 0, 2'b11, 0, 1, 8'hFB);
        cyc("R9 clear", 0, 2'b11, 0, 1, 8'h7B);
        check("R10 irq low", {15'h0, irq}, 16'h0000);
        cyc("R9 write one no set", 0, 2'b11, 0, 1, 8'hFB);
        cyc("R9 violation wins", 1, 2'b10, ad(0, 0), 1, 8'h7B);
        check("R10 irq again", {15'h0, irq}, 16'h0001);
        cyc("R11 tail", 0, 2'b00, 0);
        cyc("R11 tail2", 0, 2'b00, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule